// File: doc/BRIEF.md
# Processor Status Word with Banked Stack Pointers

This block holds a processor's status word and the stack pointer registers that go with it. The status word combines three fields: a six-bit condition field, a three-bit system field and a five-bit interrupt level mask. The condition field holds the four arithmetic flags, an interrupt enable and a stack-select flag. Software or the pipeline can write the whole word at once or one field at a time. The execution stage can also update the arithmetic flags one by one through a per-bit enable.

There is one live stack register and two saved pointers, one for system mode and one for user mode. When the stack-select flag changes value, the live register is parked in the bank it belonged to and reloaded from the other bank. An access to the saved pointer that is currently active is redirected to the live register. The interrupt level mask has a raise-only rule: once the mask is in its upper half, a write of a value from the lower half lands in the upper half.

Top module: `psw_bank_regs`

## Requirements
- R1: While reset is asserted and right after it, the condition and system fields read 0, the level mask reads 15, and the live, system and user stack values read 0.
- R2: A condition-field write (cc_we, no word write) stores cc_wdata[5:0] with C at bit 0, V at bit 1, Z at bit 2, N at bit 3, interrupt enable at bit 4 and stack select at bit 5. cc_rdata[7:6] read 0.
- R3: A system-field write stores sys_wdata[2:0] (trace at bit 0, two debug bits at bits 1 and 2). The upper input bits are discarded.
- R4: A level write stores the 5-bit value it is given, except that when the current mask is 16 or more and the written value is below 16, the stored value is the written value plus 16. The mask therefore never drops from 16 or more to below 16.
- R5: word_rdata carries the condition field in bits 5:0, the system field in bits 10:8 and the level mask in bits 20:16, with all other bits zero. A word write splits its data into these positions, applies R2 to R4 to each field, and takes priority over field writes in the same cycle.
- R6: Each flag_en bit i (0=C, 1=V, 2=Z, 3=N) loads flag_val[i] into that flag. These updates are ignored in a cycle that also writes the condition field or the whole word.
- R7: When stack select changes from 1 to 0, the live stack value is saved as the user pointer and the live register is loaded from the saved system pointer.
- R8: When stack select changes from 0 to 1, the live stack value is saved as the system pointer and the live register is loaded from the saved user pointer.
- R9: While stack select is 0, ssp_rdata and ssp writes refer to the live register. While it is 1, usp_rdata and usp writes refer to the live register. Otherwise they refer to the saved pointer.
- R10: A write that leaves stack select at its current value causes no stack movement.
- R11: In a cycle with both a stack-select change and stack writes, the swap happens first and the writes follow under the new select value. A sp_we write wins over a redirected ssp or usp write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_we | input | 1 | Whole status word write enable |
| word_wdata | input | DATA_W | Whole status word write data |
| word_rdata | output | DATA_W | Packed status word |
| cc_we | input | 1 | Condition field write enable |
| cc_wdata | input | 8 | Condition field write data |
| cc_rdata | output | 8 | Condition field, zero-extended |
| sys_we | input | 1 | System field write enable |
| sys_wdata | input | 8 | System field write data |
| sys_rdata | output | 3 | System field |
| lvl_we | input | 1 | Level mask write enable |
| lvl_wdata | input | 8 | Level mask write data |
| lvl_rdata | output | 5 | Level mask |
| flag_en | input | 4 | Per-flag update enables (C,V,Z,N) |
| flag_val | input | 4 | Per-flag update values |
| sp_we | input | 1 | Live stack register write enable |
| sp_wdata | input | DATA_W | Live stack register write data |
| sp_rdata | output | DATA_W | Live stack register |
| ssp_we | input | 1 | System stack pointer write enable |
| ssp_wdata | input | DATA_W | System stack pointer write data |
| ssp_rdata | output | DATA_W | System stack pointer view |
| usp_we | input | 1 | User stack pointer write enable |
| usp_wdata | input | DATA_W | User stack pointer write data |
| usp_rdata | output | DATA_W | User stack pointer view |

## Verification
Some properties are checked on every cycle. These are: the mask staying in its upper half once there, a condition write landing on the next cycle, per-flag updates taking effect, the contents moved by a swap in either direction, and all three stack views holding still when the select bit is unchanged. Other behaviour can only be shown by the bench's sweeps against its own arithmetic model. This covers the full 32-by-32 table of mask start and write values, the discarded upper input bits, word-over-field priority, redirected stack accesses, and the ordering of a select change against simultaneous stack writes.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int CC_BITS   = 6;
  localparam int SYS_BITS  = 3;
  localparam int LVL_BITS  = 5;
  localparam int ARITH_N   = 4;
  localparam int FIELD_IN_W = 8;

  localparam int CC_S_POS      = 5;
  localparam int WORD_SYS_LSB  = 8;
  localparam int WORD_LVL_LSB  = 16;

  typedef logic [CC_BITS-1:0]  cc_t;
  typedef logic [SYS_BITS-1:0] sys_t;
  typedef logic [LVL_BITS-1:0] lvl_t;

  localparam lvl_t LVL_HIGH  = lvl_t'(1) << (LVL_BITS-1);
  localparam lvl_t LVL_RESET = LVL_HIGH - lvl_t'(1);

  // Raise-only rule: an upper-half mask keeps its upper half.
  function automatic lvl_t lvl_apply(input lvl_t cur, input lvl_t req);
    lvl_t res;
    if (cur[LVL_BITS-1] && !req[LVL_BITS-1]) res = req | LVL_HIGH;
    else                                      res = req;
    return res;
  endfunction
endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/psw_field_unit.sv
module psw_field_unit
  import psw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  word_we,
  input  logic [DATA_W-1:0]     word_wdata,
  input  logic                  cc_we,
  input  logic [FIELD_IN_W-1:0] cc_wdata,
  input  logic                  sys_we,
  input  logic [FIELD_IN_W-1:0] sys_wdata,
  input  logic                  lvl_we,
  input  logic [FIELD_IN_W-1:0] lvl_wdata,
  input  logic [ARITH_N-1:0]    flag_en,
  input  logic [ARITH_N-1:0]    flag_val,
  output cc_t                   cc_q,
  output sys_t                  sys_q,
  output lvl_t                  lvl_q,
  output logic                  sel_next
);
  logic cc_load, cc_ce, sys_ce, lvl_ce;
  cc_t  cc_src, cc_n;
  sys_t sys_n;
  lvl_t lvl_src, lvl_n;

  always_comb begin
    cc_load = word_we | cc_we;
    cc_src  = word_we ? word_wdata[CC_BITS-1:0] : cc_wdata[CC_BITS-1:0];
    cc_ce   = cc_load | (|flag_en);
  end

  // Arithmetic flags take per-bit updates; the rest only whole loads.
  for (genvar b = 0; b < CC_BITS; b++) begin : g_cc
    if (b < ARITH_N) begin : g_arith
      assign cc_n[b] = cc_load ? cc_src[b] : (flag_en[b] ? flag_val[b] : cc_q[b]);
    end else begin : g_ctrl
      assign cc_n[b] = cc_load ? cc_src[b] : cc_q[b];
    end
  end

  always_comb begin
    sys_ce  = word_we | sys_we;
    sys_n   = word_we ? word_wdata[WORD_SYS_LSB +: SYS_BITS] : sys_wdata[SYS_BITS-1:0];
    lvl_ce  = word_we | lvl_we;
    lvl_src = word_we ? word_wdata[WORD_LVL_LSB +: LVL_BITS] : lvl_wdata[LVL_BITS-1:0];
    lvl_n   = lvl_apply(lvl_q, lvl_src);
  end

  assign sel_next = cc_n[CC_S_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q  <= '0;
      sys_q <= '0;
      lvl_q <= LVL_RESET;
    end else begin
      if (cc_ce)  cc_q  <= cc_n;
      if (sys_ce) sys_q <= sys_n;
      if (lvl_ce) lvl_q <= lvl_n;
    end
  end
endmodule

// File: rtl/psw_stack_bank.sv
module psw_stack_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_cur,
  input  logic              sel_next,
  input  logic              sp_we,
  input  logic [DATA_W-1:0] sp_wdata,
  input  logic              ssp_we,
  input  logic [DATA_W-1:0] ssp_wdata,
  input  logic              usp_we,
  input  logic [DATA_W-1:0] usp_wdata,
  output logic [DATA_W-1:0] sp_rdata,
  output logic [DATA_W-1:0] ssp_rdata,
  output logic [DATA_W-1:0] usp_rdata
);
  logic [DATA_W-1:0] live_q, sys_bank_q, usr_bank_q;
  logic [DATA_W-1:0] live_n, sys_bank_n, usr_bank_n;
  logic              swap, live_ce, sys_ce, usr_ce;

  always_comb begin
    swap       = sel_cur ^ sel_next;
    live_n     = live_q;
    sys_bank_n = sys_bank_q;
    usr_bank_n = usr_bank_q;
    live_ce    = swap | sp_we;
    sys_ce     = 1'b0;
    usr_ce     = 1'b0;
    // Swap first, then writes under the new select value.
    if (swap) begin
      if (sel_cur) begin
        usr_bank_n = live_q;
        live_n     = sys_bank_q;
        usr_ce     = 1'b1;
      end else begin
        sys_bank_n = live_q;
        live_n     = usr_bank_q;
        sys_ce     = 1'b1;
      end
    end
    if (ssp_we) begin
      if (!sel_next) begin
        live_n  = ssp_wdata;
        live_ce = 1'b1;
      end else begin
        sys_bank_n = ssp_wdata;
        sys_ce     = 1'b1;
      end
    end
    if (usp_we) begin
      if (sel_next) begin
        live_n  = usp_wdata;
        live_ce = 1'b1;
      end else begin
        usr_bank_n = usp_wdata;
        usr_ce     = 1'b1;
      end
    end
    if (sp_we) live_n = sp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q     <= '0;
      sys_bank_q <= '0;
      usr_bank_q <= '0;
    end else begin
      if (live_ce) live_q     <= live_n;
      if (sys_ce)  sys_bank_q <= sys_bank_n;
      if (usr_ce)  usr_bank_q <= usr_bank_n;
    end
  end

  assign sp_rdata  = live_q;
  assign ssp_rdata = sel_cur ? sys_bank_q : live_q;
  assign usp_rdata = sel_cur ? live_q : usr_bank_q;
endmodule

// File: rtl/psw_bank_regs.sv
module psw_bank_regs
  import psw_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  word_we,
  input  logic [DATA_W-1:0]     word_wdata,
  output logic [DATA_W-1:0]     word_rdata,
  input  logic                  cc_we,
  input  logic [FIELD_IN_W-1:0] cc_wdata,
  output logic [FIELD_IN_W-1:0] cc_rdata,
  input  logic                  sys_we,
  input  logic [FIELD_IN_W-1:0] sys_wdata,
  output logic [SYS_BITS-1:0]   sys_rdata,
  input  logic                  lvl_we,
  input  logic [FIELD_IN_W-1:0] lvl_wdata,
  output logic [LVL_BITS-1:0]   lvl_rdata,
  input  logic [ARITH_N-1:0]    flag_en,
  input  logic [ARITH_N-1:0]    flag_val,
  input  logic                  sp_we,
  input  logic [DATA_W-1:0]     sp_wdata,
  output logic [DATA_W-1:0]     sp_rdata,
  input  logic                  ssp_we,
  input  logic [DATA_W-1:0]     ssp_wdata,
  output logic [DATA_W-1:0]     ssp_rdata,
  input  logic                  usp_we,
  input  logic [DATA_W-1:0]     usp_wdata,
  output logic [DATA_W-1:0]     usp_rdata
);
  localparam int CC_PAD = FIELD_IN_W - CC_BITS;

  logic rst_sync_n;
  logic sel_next;
  cc_t  cc_q;
  sys_t sys_q;
  lvl_t lvl_q;

  psw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psw_field_unit #(.DATA_W(DATA_W)) u_fields (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .word_we    (word_we),
    .word_wdata (word_wdata),
    .cc_we      (cc_we),
    .cc_wdata   (cc_wdata),
    .sys_we     (sys_we),
    .sys_wdata  (sys_wdata),
    .lvl_we     (lvl_we),
    .lvl_wdata  (lvl_wdata),
    .flag_en    (flag_en),
    .flag_val   (flag_val),
    .cc_q       (cc_q),
    .sys_q      (sys_q),
    .lvl_q      (lvl_q),
    .sel_next   (sel_next)
  );

  psw_stack_bank #(.DATA_W(DATA_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel_cur   (cc_q[CC_S_POS]),
    .sel_next  (sel_next),
    .sp_we     (sp_we),
    .sp_wdata  (sp_wdata),
    .ssp_we    (ssp_we),
    .ssp_wdata (ssp_wdata),
    .usp_we    (usp_we),
    .usp_wdata (usp_wdata),
    .sp_rdata  (sp_rdata),
    .ssp_rdata (ssp_rdata),
    .usp_rdata (usp_rdata)
  );

  always_comb begin
    word_rdata = '0;
    word_rdata[CC_BITS-1:0]               = cc_q;
    word_rdata[WORD_SYS_LSB +: SYS_BITS]  = sys_q;
    word_rdata[WORD_LVL_LSB +: LVL_BITS]  = lvl_q;
  end

  assign cc_rdata  = {{CC_PAD{1'b0}}, cc_q};
  assign sys_rdata = sys_q;
  assign lvl_rdata = lvl_q;
endmodule

// File: rtl/psw_bank_regs_chk.sv
module psw_bank_regs_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_we,
  input logic              cc_we,
  input logic [7:0]        cc_wdata,
  input logic [7:0]        cc_rdata,
  input logic [4:0]        lvl_rdata,
  input logic [3:0]        flag_en,
  input logic [3:0]        flag_val,
  input logic              sp_we,
  input logic              ssp_we,
  input logic              usp_we,
  input logic [DATA_W-1:0] sp_rdata,
  input logic [DATA_W-1:0] ssp_rdata,
  input logic [DATA_W-1:0] usp_rdata
);
  AST_LVL_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_rdata[4] |=> lvl_rdata[4]); // R4

  AST_CC_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_we && !word_we) |=> (cc_rdata == {2'b00, $past(cc_wdata[5:0])})); // R2

  AST_CARRY_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en[0] && !cc_we && !word_we) |=> (cc_rdata[0] == $past(flag_val[0]))); // R6

  AST_NEG_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en[3] && !cc_we && !word_we) |=> (cc_rdata[3] == $past(flag_val[3]))); // R6

  AST_SWAP_TO_USER: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cc_rdata[5]) && !$past(sp_we) && !$past(ssp_we) && !$past(usp_we))
    |-> (sp_rdata == $past(usp_rdata) && ssp_rdata == $past(sp_rdata))); // R8

  AST_SWAP_TO_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cc_rdata[5]) && !$past(sp_we) && !$past(ssp_we) && !$past(usp_we))
    |-> (sp_rdata == $past(ssp_rdata) && usp_rdata == $past(sp_rdata))); // R7

  AST_NO_SWAP_SAME_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cc_rdata[5]) && !$past(sp_we) && !$past(ssp_we) && !$past(usp_we))
    |-> ($stable(sp_rdata) && $stable(ssp_rdata) && $stable(usp_rdata))); // R10
endmodule

bind psw_bank_regs psw_bank_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .word_we   (word_we),
  .cc_we     (cc_we),
  .cc_wdata  (cc_wdata),
  .cc_rdata  (cc_rdata),
  .lvl_rdata (lvl_rdata),
  .flag_en   (flag_en),
  .flag_val  (flag_val),
  .sp_we     (sp_we),
  .ssp_we    (ssp_we),
  .usp_we    (usp_we),
  .sp_rdata  (sp_rdata),
  .ssp_rdata (ssp_rdata),
  .usp_rdata (usp_rdata)
);

// File: tb/psw_bank_regs_test.sv
`timescale 1ns/1ps
module psw_bank_regs_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         word_we = 1'b0;
  logic [W-1:0] word_wdata = '0;
  logic [W-1:0] word_rdata;
  logic         cc_we = 1'b0;
  logic [7:0]   cc_wdata = '0;
  logic [7:0]   cc_rdata;
  logic         sys_we = 1'b0;
  logic [7:0]   sys_wdata = '0;
  logic [2:0]   sys_rdata;
  logic         lvl_we = 1'b0;
  logic [7:0]   lvl_wdata = '0;
  logic [4:0]   lvl_rdata;
  logic [3:0]   flag_en = '0;
  logic [3:0]   flag_val = '0;
  logic         sp_we = 1'b0, ssp_we = 1'b0, usp_we = 1'b0;
  logic [W-1:0] sp_wdata = '0, ssp_wdata = '0, usp_wdata = '0;
  logic [W-1:0] sp_rdata, ssp_rdata, usp_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  // Bench model state
  logic [5:0]   m_cc;
  logic [2:0]   m_sys;
  logic [4:0]   m_lvl;
  logic [W-1:0] m_live, m_sysb, m_usrb;

  always #2.5 clk = ~clk;

  psw_bank_regs uut (
    .clk(clk), .rst_n(rst_n),
    .word_we(word_we), .word_wdata(word_wdata), .word_rdata(word_rdata),
    .cc_we(cc_we), .cc_wdata(cc_wdata), .cc_rdata(cc_rdata),
    .sys_we(sys_we), .sys_wdata(sys_wdata), .sys_rdata(sys_rdata),
    .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .lvl_rdata(lvl_rdata),
    .flag_en(flag_en), .flag_val(flag_val),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata),
    .ssp_we(ssp_we), .ssp_wdata(ssp_wdata), .ssp_rdata(ssp_rdata),
    .usp_we(usp_we), .usp_wdata(usp_wdata), .usp_rdata(usp_rdata)
  );

  function automatic logic [4:0] lvl_rule(input logic [4:0] cur, input logic [4:0] req);
    return (cur >= 5'd16 && req < 5'd16) ? req + 5'd16 : req;
  endfunction

  task automatic compare(input string tag);
    logic [W-1:0] e_word, e_ssp, e_usp;
    e_word = {11'd0, m_lvl, 5'd0, m_sys, 2'd0, m_cc};
    e_ssp  = m_cc[5] ? m_sysb : m_live;
    e_usp  = m_cc[5] ? m_live : m_usrb;
    n_tests++;
    if (word_rdata !== e_word || cc_rdata !== {2'b00, m_cc} || sys_rdata !== m_sys ||
        lvl_rdata !== m_lvl || sp_rdata !== m_live || ssp_rdata !== e_ssp ||
        usp_rdata !== e_usp) begin
      n_fail++;
      $display("FAIL %s: word=%h/%h cc=%h/%h sys=%h/%h lvl=%0d/%0d sp=%h/%h ssp=%h/%h usp=%h/%h (actual/expected)",
               tag, word_rdata, e_word, cc_rdata, {2'b00, m_cc}, sys_rdata, m_sys,
               lvl_rdata, m_lvl, sp_rdata, m_live, ssp_rdata, e_ssp, usp_rdata, e_usp);
    end
  endtask

  // Apply the inputs present now for one clock, update the model, check.
  task automatic step(input string tag);
    logic [5:0] n_cc;
    logic       s_old, s_new;
    n_cc = m_cc;
    if (word_we)      n_cc = word_wdata[5:0];
    else if (cc_we)   n_cc = cc_wdata[5:0];
    else for (int b = 0; b < 4; b++) if (flag_en[b]) n_cc[b] = flag_val[b];
    s_old = m_cc[5];
    s_new = n_cc[5];
    if (s_old && !s_new)      begin m_usrb = m_live; m_live = m_sysb; end
    else if (!s_old && s_new) begin m_sysb = m_live; m_live = m_usrb; end
    if (ssp_we) begin if (!s_new) m_live = ssp_wdata; else m_sysb = ssp_wdata; end
    if (usp_we) begin if (s_new)  m_live = usp_wdata; else m_usrb = usp_wdata; end
    if (sp_we) m_live = sp_wdata;
    if (word_we)     m_sys = word_wdata[10:8];
    else if (sys_we) m_sys = sys_wdata[2:0];
    if (word_we)     m_lvl = lvl_rule(m_lvl, word_wdata[20:16]);
    else if (lvl_we) m_lvl = lvl_rule(m_lvl, lvl_wdata[4:0]);
    m_cc = n_cc;
    @(posedge clk);
    #1;
    compare(tag);
    @(negedge clk);
    word_we = 0; cc_we = 0; sys_we = 0; lvl_we = 0; flag_en = '0;
    sp_we = 0; ssp_we = 0; usp_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_cc = '0; m_sys = '0; m_lvl = 5'd15; m_live = '0; m_sysb = '0; m_usrb = '0;
    #3;
    compare("R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 after release");
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();

    // R2: every condition byte value
    for (int v = 0; v < 256; v++) begin
      cc_we = 1; cc_wdata = 8'(v); step("R2 cc write");
    end
    // R3: every system byte value
    for (int v = 0; v < 256; v++) begin
      sys_we = 1; sys_wdata = 8'(v); step("R3 sys write");
    end
    // R4: every start mask against every written value (upper input bits set)
    for (int st = 0; st < 32; st++) begin
      for (int wv = 0; wv < 32; wv++) begin
        do_reset();
        lvl_we = 1; lvl_wdata = 8'(st); step("R4 set start");
        lvl_we = 1; lvl_wdata = 8'(wv) | 8'hE0; step("R4 raise-only");
      end
    end
    do_reset();
    // R5: whole-word writes, some colliding with field writes
    for (int i = 0; i < 96; i++) begin
      word_we = 1; word_wdata = 32'h9E37_79B9 * (i + 1);
      cc_we = i[0]; cc_wdata = 8'h15; lvl_we = i[1]; lvl_wdata = 8'h03;
      sys_we = i[2]; sys_wdata = 8'h05; flag_en = 4'hF; flag_val = 4'(i);
      step("R5 word write");
    end
    // R6: per-flag updates, and ignored under a condition write
    for (int e = 0; e < 16; e++) begin
      for (int v = 0; v < 16; v++) begin
        flag_en = 4'(e); flag_val = 4'(v); step("R6 flag update");
      end
      flag_en = 4'(e); flag_val = ~4'(e); cc_we = 1; cc_wdata = 8'(e * 3);
      step("R6 flags ignored on cc write");
    end
    // Stack directed sequence
    do_reset();
    sp_we = 1; sp_wdata = 32'hAAAA_0001; step("R9 live write sel0");
    usp_we = 1; usp_wdata = 32'hBBBB_0002; step("R9 usp to bank sel0");
    ssp_we = 1; ssp_wdata = 32'hCCCC_0003; step("R9 ssp to live sel0");
    cc_we = 1; cc_wdata = 8'h20; step("R8 swap to user");
    ssp_we = 1; ssp_wdata = 32'hDDDD_0004; step("R9 ssp to bank sel1");
    usp_we = 1; usp_wdata = 32'hEEEE_0005; step("R9 usp to live sel1");
    cc_we = 1; cc_wdata = 8'h2F; step("R10 same select via cc");
    word_we = 1; word_wdata = 32'h0013_0520; step("R10 same select via word");
    cc_we = 1; cc_wdata = 8'h00; step("R7 swap to system");
    cc_we = 1; cc_wdata = 8'h00; step("R10 same select zero");
    cc_we = 1; cc_wdata = 8'h20; ssp_we = 1; ssp_wdata = 32'h1111_0006;
    step("R11 swap then ssp write");
    cc_we = 1; cc_wdata = 8'h00; sp_we = 1; sp_wdata = 32'h2222_0007;
    ssp_we = 1; ssp_wdata = 32'h3333_0008; step("R11 live write wins");
    // R11: sweep all combinations of stack writes and select moves
    for (int rep = 0; rep < 4; rep++) begin
      for (int k = 0; k < 32; k++) begin
        sp_we = k[0]; ssp_we = k[1]; usp_we = k[2];
        cc_we = k[3]; cc_wdata = k[4] ? 8'h20 : 8'h00;
        sp_wdata  = 32'h1000_0000 + 32'(rep * 64 + k);
        ssp_wdata = 32'h2000_0000 + 32'(rep * 64 + k);
        usp_wdata = 32'h3000_0000 + 32'(rep * 64 + k);
        step("R11 stack sweep");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule